// File: doc/BRIEF.md
# Register File with Per-Entry Logic Units

This block is a small register file in which every entry carries its own logic unit. When an instruction names the same register as its destination and its first source, the work is done inside that entry. The other operand is read through the single shared read port and broadcast to all entries. Only the target entry latches the result. No write-back path is used for these operations, and the entry itself acts as the result latch.

Overwriting a value in place is only safe when nothing still needs the old value. Each entry therefore keeps a saturating count of tracked reads that have issued but not yet completed. Each entry also keeps a speculation flag, which is set by a speculation event and cleared by a later conventional write to that entry or by resolution.

An in-place request that would break either rule is refused in the same cycle through a reject output, and the requester then sends the operation down its ordinary execution path. A conventional write port loads results produced by that path.

Top module: `inplace_regfile`

## Requirements
- R1: A synchronous reset clears every entry to zero, every pending-read count to zero and every speculation flag.
- R2: In-place operation codes 000 (AND), 001 (OR) and 010 (XOR) replace the destination with the destination combined with the source entry. The new value can be read on the cycle after the request is granted.
- R3: When ARITH=1, code 011 stores destination plus source and code 100 stores destination minus source, both modulo 2^DW.
- R4: Codes 101, 110 and 111 are accepted with op_ready and no reject, and leave every entry unchanged. The same applies to 011 and 100 when ARITH=0.
- R5: The second operand travels on the shared read port. While op_valid is high, rd_ready is low and rd_data carries the old value of entry op_src, including when op_src equals op_dst.
- R6: A read accepted with rd_track high adds one to the entry's pending count, and a done_valid pulse subtracts one. A legal in-place request on an entry whose count is nonzero is rejected in that cycle and leaves the entry unchanged.
- R7: The pending count saturates at 2^CW-1 (3 by default) and does not go below zero.
- R8: spec_mark sets the speculation flag of every entry. A conventional write clears the flag of the written entry, and spec_resolve clears all flags. If spec_mark arrives in the same cycle as a write or a resolve, spec_mark wins. A legal in-place request on a flagged entry is rejected.
- R9: A legal in-place request is rejected when a conventional write targets the same entry in the same cycle, and the write takes effect. A write to a different entry does not block the request.
- R10: op_ready and op_reject are never high together, and both are low when op_valid is low.
- R11: A granted in-place operation changes no entry other than its destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Conventional write strobe, always accepted |
| wr_idx | input | IW | Conventional write index |
| wr_data | input | DW | Conventional write data |
| rd_valid | input | 1 | Read request on the shared port |
| rd_ready | output | 1 | Read port free, i.e. no in-place request this cycle |
| rd_idx | input | IW | Read index |
| rd_track | input | 1 | Count this read as pending until done |
| rd_data | output | DW | Shared port data, the operand source while op_valid is high |
| done_valid | input | 1 | A tracked read has completed |
| done_idx | input | IW | Entry whose tracked read completed |
| op_valid | input | 1 | In-place request |
| op_ready | output | 1 | Request consumed by the register file |
| op_reject | output | 1 | Request refused, route to the side path |
| op_dst | input | IW | Destination and first source |
| op_src | input | IW | Second source, broadcast to all entries |
| op_code | input | 3 | Operation code |
| spec_mark | input | 1 | Speculation event |
| spec_resolve | input | 1 | All speculation resolved |

## Verification
The bench sweeps every operation code over every destination with a rotating source. The sweep includes source equal to destination, so a design that read the freshly written value, or that broadcast the wrong operand, would return a wrong XOR, AND or difference. After each operation it reads the destination and a neighbour, which catches a decoder that writes to several entries at once.

The pending counter is pushed past saturation and then below zero. A counter that wraps would either clear itself after four reads or become nonzero after an extra completion, and the bench would see a grant where a reject is due, or the reverse.

Speculation is checked against the order of its three events: mark, write and resolve. A write that collides with a request is also checked, because a design that let both land would lose the written value.

// File: rtl/inrf_pkg.sv
package inrf_pkg;

  typedef enum logic [2:0] {
    OPC_AND = 3'b000,
    OPC_OR  = 3'b001,
    OPC_XOR = 3'b010,
    OPC_ADD = 3'b011,
    OPC_SUB = 3'b100
  } inrf_opc_e;

  // A code is legal when it names a unit that exists in this configuration.
  function automatic logic op_legal(input logic [2:0] code, input bit arith);
    logic ok;
    ok = (code == OPC_AND) || (code == OPC_OR) || (code == OPC_XOR);
    if (arith) ok = ok || (code == OPC_ADD) || (code == OPC_SUB);
    return ok;
  endfunction

endpackage

// File: rtl/inrf_dec.sv
module inrf_dec #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          en,
  input  logic [IW-1:0] idx,
  output logic [N-1:0]  hit
);
  for (genvar g = 0; g < N; g++) begin : g_line
    assign hit[g] = en && (idx == IW'(g));
  end
endmodule

// File: rtl/inrf_entry.sv
module inrf_entry
  import inrf_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CW    = 2,
  parameter bit ARITH = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_hit,
  input  logic [DW-1:0] wr_data,
  input  logic          op_hit,
  input  logic [2:0]    op_code,
  input  logic [DW-1:0] bcast,
  input  logic          rd_inc,
  input  logic          rd_dec,
  input  logic          spec_mark,
  input  logic          spec_resolve,
  output logic [DW-1:0] value,
  output logic          busy,
  output logic          spec
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] pend_q;
  logic [DW-1:0] sum, diff, alu_res;

  // Adder/subtractor exist only in the larger configuration.
  if (ARITH) begin : g_arith
    assign sum  = value + bcast;
    assign diff = value - bcast;
  end else begin : g_logic_only
    assign sum  = value;
    assign diff = value;
  end

  always_comb begin
    unique case (op_code)
      OPC_AND: alu_res = value & bcast;
      OPC_OR:  alu_res = value | bcast;
      OPC_XOR: alu_res = value ^ bcast;
      OPC_ADD: alu_res = sum;
      OPC_SUB: alu_res = diff;
      default: alu_res = value;
    endcase
  end

  // The entry is its own result latch.
  always_ff @(posedge clk) begin
    if (rst)         value <= '0;
    else if (wr_hit) value <= wr_data;
    else if (op_hit) value <= alu_res;
  end

  always_ff @(posedge clk) begin
    if (rst)
      pend_q <= '0;
    else if (rd_inc && !rd_dec && pend_q != CMAX)
      pend_q <= pend_q + 1'b1;
    else if (rd_dec && !rd_inc && pend_q != '0)
      pend_q <= pend_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)               spec <= 1'b0;
    else if (spec_mark)    spec <= 1'b1;
    else if (wr_hit)       spec <= 1'b0;
    else if (spec_resolve) spec <= 1'b0;
  end

  assign busy = (pend_q != '0);
endmodule

// File: rtl/inrf_guard.sv
module inrf_guard
  import inrf_pkg::*;
#(
  parameter int N     = 8,
  parameter int IW    = 3,
  parameter bit ARITH = 1'b1
) (
  input  logic          op_valid,
  input  logic [IW-1:0] op_dst,
  input  logic [2:0]    op_code,
  input  logic [N-1:0]  busy,
  input  logic [N-1:0]  spec,
  input  logic          wr_valid,
  input  logic [IW-1:0] wr_idx,
  output logic          op_ready,
  output logic          op_reject,
  output logic          grant
);
  logic legal, clash, blocked;

  always_comb begin
    legal     = op_legal(op_code, ARITH);
    clash     = wr_valid && (wr_idx == op_dst);
    blocked   = busy[op_dst] || spec[op_dst] || clash;
    grant     = op_valid && legal && !blocked;
    op_reject = op_valid && legal && blocked;
    op_ready  = op_valid && !(legal && blocked);
  end
endmodule

// File: rtl/inplace_regfile.sv
module inplace_regfile
  import inrf_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int DW    = 16,
  parameter int CW    = 2,
  parameter bit ARITH = 1'b1,
  localparam int IW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [IW-1:0] rd_idx,
  input  logic          rd_track,
  output logic [DW-1:0] rd_data,
  input  logic          done_valid,
  input  logic [IW-1:0] done_idx,
  input  logic          op_valid,
  output logic          op_ready,
  output logic          op_reject,
  input  logic [IW-1:0] op_dst,
  input  logic [IW-1:0] op_src,
  input  logic [2:0]    op_code,
  input  logic          spec_mark,
  input  logic          spec_resolve
);
  logic [NREG-1:0][DW-1:0] vals;
  logic [NREG-1:0] busy, spec, wr_hit, op_hit, inc_hit, dec_hit;
  logic            grant;
  logic [IW-1:0]   port_sel;

  // The single read port serves the operand whenever an in-place request is present.
  assign rd_ready = !op_valid;
  assign port_sel = op_valid ? op_src : rd_idx;
  assign rd_data  = vals[port_sel];

  inrf_dec #(.N(NREG), .IW(IW)) u_wr_dec (
    .en(wr_valid), .idx(wr_idx), .hit(wr_hit));
  inrf_dec #(.N(NREG), .IW(IW)) u_op_dec (
    .en(grant), .idx(op_dst), .hit(op_hit));
  inrf_dec #(.N(NREG), .IW(IW)) u_inc_dec (
    .en(rd_valid && rd_ready && rd_track), .idx(rd_idx), .hit(inc_hit));
  inrf_dec #(.N(NREG), .IW(IW)) u_dec_dec (
    .en(done_valid), .idx(done_idx), .hit(dec_hit));

  inrf_guard #(.N(NREG), .IW(IW), .ARITH(ARITH)) u_guard (
    .op_valid(op_valid), .op_dst(op_dst), .op_code(op_code),
    .busy(busy), .spec(spec), .wr_valid(wr_valid), .wr_idx(wr_idx),
    .op_ready(op_ready), .op_reject(op_reject), .grant(grant));

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    inrf_entry #(.DW(DW), .CW(CW), .ARITH(ARITH)) u_ent (
      .clk(clk), .rst(rst),
      .wr_hit(wr_hit[g]), .wr_data(wr_data),
      .op_hit(op_hit[g]), .op_code(op_code), .bcast(rd_data),
      .rd_inc(inc_hit[g]), .rd_dec(dec_hit[g]),
      .spec_mark(spec_mark), .spec_resolve(spec_resolve),
      .value(vals[g]), .busy(busy[g]), .spec(spec[g]));
  end
endmodule

// File: rtl/inplace_regfile_chk.sv
module inplace_regfile_chk
  import inrf_pkg::*;
#(
  parameter int DW    = 16,
  parameter bit ARITH = 1'b1,
  parameter int IW    = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_valid,
  input logic [IW-1:0] wr_idx,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [IW-1:0] rd_idx,
  input logic          rd_track,
  input logic [DW-1:0] rd_data,
  input logic          done_valid,
  input logic [IW-1:0] done_idx,
  input logic          op_valid,
  input logic          op_ready,
  input logic          op_reject,
  input logic [IW-1:0] op_dst,
  input logic [2:0]    op_code,
  input logic          spec_mark
);
  logic legal;
  assign legal = op_legal(op_code, ARITH);

  a_r1_cleared: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && rd_valid) |-> (rd_data == '0));

  a_r5_port_taken: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> !rd_ready);

  a_r6_pending_blocks: assert property (@(posedge clk) disable iff (rst)
    (op_valid && legal && $past(rd_valid && rd_ready && rd_track) &&
     $past(rd_idx) == op_dst &&
     !($past(done_valid) && $past(done_idx) == op_dst)) |-> op_reject);

  a_r8_spec_blocks: assert property (@(posedge clk) disable iff (rst)
    (op_valid && legal && $past(spec_mark)) |-> op_reject);

  a_r9_write_clash: assert property (@(posedge clk) disable iff (rst)
    (op_valid && legal && wr_valid && wr_idx == op_dst) |-> op_reject);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(op_ready && op_reject));

  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    !op_valid |-> (!op_ready && !op_reject));
endmodule

bind inplace_regfile inplace_regfile_chk #(.DW(DW), .ARITH(ARITH), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_idx(wr_idx),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_idx(rd_idx),
  .rd_track(rd_track), .rd_data(rd_data), .done_valid(done_valid),
  .done_idx(done_idx), .op_valid(op_valid), .op_ready(op_ready),
  .op_reject(op_reject), .op_dst(op_dst), .op_code(op_code),
  .spec_mark(spec_mark));

// File: tb/test_inplace_regfile.sv
`timescale 1ns/1ps
module test_inplace_regfile;
  localparam int N = 8, DW = 16, IW = 3, CMAX = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 1'b0, rd_valid = 1'b0, rd_track = 1'b0, done_valid = 1'b0;
  logic op_valid = 1'b0, spec_mark = 1'b0, spec_resolve = 1'b0;
  logic [IW-1:0] wr_idx = '0, rd_idx = '0, done_idx = '0, op_dst = '0, op_src = '0;
  logic [DW-1:0] wr_data = '0;
  logic [2:0] op_code = '0;
  logic rd_ready, op_ready, op_reject;
  logic [DW-1:0] rd_data;

  always #2.5 clk = ~clk;

  inplace_regfile i_inplace_regfile (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_idx(rd_idx), .rd_track(rd_track),
    .rd_data(rd_data), .done_valid(done_valid), .done_idx(done_idx),
    .op_valid(op_valid), .op_ready(op_ready), .op_reject(op_reject),
    .op_dst(op_dst), .op_src(op_src), .op_code(op_code),
    .spec_mark(spec_mark), .spec_resolve(spec_resolve));

  int total = 0, bad = 0;
  logic [DW-1:0] mdl [N];
  int cnt [N];
  bit sflag [N];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_valid = 0; rd_valid = 0; rd_track = 0; done_valid = 0;
    op_valid = 0; spec_mark = 0; spec_resolve = 0;
  endtask

  function automatic logic [DW-1:0] calc(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                         input int c);
    case (c)
      0: return a & b;
      1: return a | b;
      2: return a ^ b;
      3: return a + b;
      4: return a - b;
      default: return a;
    endcase
  endfunction

  task automatic do_write(input int i, input logic [DW-1:0] d);
    @(negedge clk); idle();
    wr_valid = 1; wr_idx = IW'(i); wr_data = d;
    mdl[i] = d; sflag[i] = 0;
  endtask

  task automatic peek(input int i, input string req);
    @(negedge clk); idle();
    rd_valid = 1; rd_idx = IW'(i);
    #1;
    chk(rd_data == mdl[i], req, rd_data, mdl[i]);
  endtask

  task automatic tread(input int i);
    @(negedge clk); idle();
    rd_valid = 1; rd_track = 1; rd_idx = IW'(i);
    if (cnt[i] < CMAX) cnt[i]++;
  endtask

  task automatic tdone(input int i);
    @(negedge clk); idle();
    done_valid = 1; done_idx = IW'(i);
    if (cnt[i] > 0) cnt[i]--;
  endtask

  // In-place request; optional same-cycle write (wi < 0 means none).
  task automatic op(input int d, input int s, input int c, input string req,
                    input int wi = -1, input logic [DW-1:0] wd = '0);
    bit legal, blk, exp_rdy, exp_rej;
    logic [DW-1:0] res;
    @(negedge clk); idle();
    op_valid = 1; op_dst = IW'(d); op_src = IW'(s); op_code = 3'(c);
    if (wi >= 0) begin wr_valid = 1; wr_idx = IW'(wi); wr_data = wd; end
    legal   = (c <= 4);
    blk     = (cnt[d] != 0) || sflag[d] || (wi == d);
    exp_rej = legal && blk;
    exp_rdy = !exp_rej;
    res     = calc(mdl[d], mdl[s], c);
    #1;
    chk(op_ready == exp_rdy, req, op_ready, exp_rdy);
    chk(op_reject == exp_rej, req, op_reject, exp_rej);
    chk(!(op_ready && op_reject), "R10", {op_ready, op_reject}, 0);
    chk(rd_ready == 1'b0, "R5", rd_ready, 0);
    chk(rd_data == mdl[s], "R5", rd_data, mdl[s]);
    if (legal && !blk) mdl[d] = res;
    if (wi >= 0) begin mdl[wi] = wd; sflag[wi] = 0; end
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin mdl[i] = '0; cnt[i] = 0; sflag[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    for (int i = 0; i < N; i++) peek(i, "R1");
    @(negedge clk); idle();
    #1;
    chk(!op_ready && !op_reject, "R10", {op_ready, op_reject}, 0);

    // R2/R3/R4/R5/R11: sweep codes, destinations and rotating sources
    for (int c = 0; c < 8; c++) begin
      for (int i = 0; i < N; i++)
        do_write(i, DW'((i * 16'h3A71) ^ (c * 16'h0F0F)) + 16'h1234);
      for (int d = 0; d < N; d++) begin
        int s;
        string req;
        s = (d * 3 + c) % N;
        req = (c < 3) ? "R2" : (c < 5) ? "R3" : "R4";
        op(d, s, c, req);
        peek(d, req);
        peek((d + 1) % N, "R11");
      end
    end

    // R3: wrap-around
    do_write(1, 16'hFFFF); do_write(2, 16'h0003);
    op(1, 2, 3, "R3"); peek(1, "R3");
    chk(mdl[1] == 16'h0002, "R3", mdl[1], 16'h0002);
    op(2, 1, 4, "R3"); peek(2, "R3");
    chk(mdl[2] == 16'h0001, "R3", mdl[2], 16'h0001);
    // R5: source equals destination, XOR self gives zero
    do_write(6, 16'hBEEF); op(6, 6, 2, "R5"); peek(6, "R5");
    chk(mdl[6] == 16'h0000, "R5", mdl[6], 0);

    // R6: outstanding read blocks
    do_write(3, 16'h00F0); do_write(4, 16'h0F0F);
    tread(3);
    op(3, 4, 1, "R6"); peek(3, "R6");
    tdone(3);
    op(3, 4, 1, "R6"); peek(3, "R6");
    chk(mdl[3] == 16'h0FFF, "R6", mdl[3], 16'h0FFF);

    // R7: saturation above and floor below
    do_write(5, 16'h1111);
    repeat (4) tread(5);
    tdone(5); tdone(5);
    op(5, 0, 2, "R7"); peek(5, "R7");
    tdone(5);
    op(5, 0, 2, "R7"); peek(5, "R7");
    tdone(5); tread(5);
    op(5, 0, 2, "R7");
    tdone(5);
    op(5, 0, 2, "R7"); peek(5, "R7");

    // R8: speculation flag life cycle
    @(negedge clk); idle(); spec_mark = 1;
    for (int i = 0; i < N; i++) sflag[i] = 1;
    op(0, 1, 0, "R8"); peek(0, "R8");
    do_write(0, 16'h5A5A);
    op(0, 1, 1, "R8"); peek(0, "R8");
    op(1, 0, 1, "R8");
    @(negedge clk); idle(); spec_resolve = 1;
    for (int i = 0; i < N; i++) sflag[i] = 0;
    op(1, 0, 1, "R8"); peek(1, "R8");
    // mark beats a write in the same cycle
    @(negedge clk); idle(); spec_mark = 1; wr_valid = 1; wr_idx = 3'd2; wr_data = 16'h7777;
    mdl[2] = 16'h7777;
    for (int i = 0; i < N; i++) sflag[i] = 1;
    op(2, 0, 2, "R8"); peek(2, "R8");
    @(negedge clk); idle(); spec_resolve = 1;
    for (int i = 0; i < N; i++) sflag[i] = 0;

    // R9: write collision
    op(7, 0, 2, "R9", 7, 16'hC0DE); peek(7, "R9");
    op(7, 0, 2, "R9", 6, 16'h4321); peek(7, "R9"); peek(6, "R9");

    @(negedge clk); idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule